// File: doc/BRIEF.md
# Boot ROM Byte-Fetch Read Packer

This block answers host reads aimed at a byte-wide boot ROM that hangs off a narrow 15-line local address bus. A read of one, two or four bytes becomes that many single-byte ROM fetches at consecutive ROM addresses. Each fetched byte lands on its own lane of a 32-bit result word, and the ready handshake is held off until every byte of the data phase has been gathered.

ROMs up to 32 KB are addressed directly by the local lines. Larger ROMs need up to 18 address bits. For those, every fetch begins with a short latch phase. The upper bits go out on a shared group of four lines, and the top line pulses once so that an external latch captures them. Only then are the low address, chip select and read strobe driven. A 3-bit size code chooses between these modes, sets the address mask, or reports that no ROM is fitted.

Top module: `bootrom_reader`

## Requirements
- R1: A byte read (`rd_size`=00) performs one fetch. The byte is placed on lane `host_addr[1:0]` (lane n is `rd_data[8n+7:8n]`), and the other lanes read zero.
- R2: A word read (`rd_size`=01) performs two fetches at consecutive ROM addresses. The second byte goes to the next lane up, wrapping from lane 3 to lane 0.
- R3: A dword read (`rd_size`=10 or 11) performs four consecutive fetches, starting on lane `host_addr[1:0]` and stepping up one lane per fetch with wrap.
- R4: `rd_ready` is a single-cycle pulse with `rd_data` valid. It appears exactly F*(W+L)+1 cycles after the cycle in which `rd_start` is sampled, where F is the number of fetches, W the effective wait count and L the latch phase length (3 or 0).
- R5: Size code `rom_size`: 000/001 mean no ROM, 010 is 8K, 011 is 16K, 100 is 32K, 101 is 64K, 110 is 128K and 111 is 256K. The ROM offset is `host_addr` masked to the size, so higher address bits are ignored, and consecutive fetch addresses wrap within the size.
- R6: With no ROM, `rom_cs_n` and `rom_oe_n` stay high, and `rd_ready` pulses one cycle after start with `rd_data` zero.
- R7: During a fetch, `rom_addr[13:0]` carries ROM A13..A0. For sizes of 32K and below, `rom_addr[14]` carries A14.
- R8: For sizes above 32K, each fetch is preceded by three cycles with chip select high: a setup cycle with A17..A14 on `rom_addr[13:10]`, a one-cycle strobe high on `rom_addr[14]`, and a hold cycle. `rom_addr[14]` is low during the fetch.
- R9: Each fetch holds `rom_cs_n` and `rom_oe_n` low for W cycles, where W = `fetch_wait`, or 1 when `fetch_wait` is 0. The ROM byte is sampled on the last of those cycles.
- R10: `rd_start` is ignored while a read is in progress. No extra response is produced, and the current result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | One-cycle read request |
| rd_size | input | 2 | 00 byte, 01 word, 1x dword |
| host_addr | input | 18 | Host byte address within the ROM window |
| rom_size | input | 3 | ROM size code (R5) |
| fetch_wait | input | 4 | Cycles per fetch (R9) |
| rd_data | output | 32 | Packed read result |
| rd_ready | output | 1 | Target-ready pulse |
| rom_addr | output | 15 | Local address lines; line 14 doubles as the latch strobe |
| rom_cs_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM read strobe, active low |
| rom_data | input | 8 | ROM data byte |

## Verification
The assertions check these properties on every cycle: the latch strobe is one cycle wide, every chip select fall for a large ROM is preceded by a strobe two cycles earlier, the read strobe never runs without chip select, chip select stays off when no ROM is fitted, and ready is a single pulse. Only the bench scenarios can show lane placement, address masking and wrap, crossing a 16K boundary where the latched upper bits change between fetches, exact latency, total strobe-low time per read, and that a start during a busy read is dropped. A bench ROM model with its own external latch returns address-dependent bytes, so any wrong address shows up as wrong data.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LSET, ST_LSTB, ST_LHLD, ST_FETCH, ST_DONE
  } fsm_t;

  // number of fetches minus one for a read size code
  function automatic logic [1:0] fetches_m1(input logic [1:0] sz);
    case (sz)
      2'b00:   fetches_m1 = 2'd0;
      2'b01:   fetches_m1 = 2'd1;
      default: fetches_m1 = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/rom_size_decode.sv
module rom_size_decode #(
  parameter int ADDR_W = 18,
  parameter int LINES  = 15
) (
  input  logic [2:0]        code_i,
  output logic              present_o,
  output logic              big_o,
  output logic [ADDR_W-1:0] mask_o
);
  localparam int DIRECT_BITS = LINES;  // bits reachable without the latch

  logic [4:0] bits;

  always_comb begin
    present_o = (code_i[2:1] != 2'b00);
    bits      = 5'(code_i) + 5'd11;
    big_o     = present_o && (int'(bits) > DIRECT_BITS);
    mask_o    = present_o ? ~({ADDR_W{1'b1}} << bits) : '0;
  end
endmodule

// File: rtl/rom_fetch_seq.sv
module rom_fetch_seq
  import bootrom_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LINES  = 15,
  parameter int HI_LO  = 10,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              present_i,
  input  logic              big_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              clr_o,
  output logic              smp_o,
  output logic [1:0]        lane_o,
  output logic              ready_o,
  output logic [LINES-1:0]  rom_addr_o,
  output logic              rom_cs_n_o,
  output logic              rom_oe_n_o
);
  localparam int HI_W = ADDR_W - LINES + 1;

  fsm_t              st_q, st_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        lane0_q, lane0_d, nf_q, nf_d, k_q, k_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d, wlast;
  logic [ADDR_W-1:0] fa;

  assign wlast  = (wait_i == '0) ? '0 : wait_i - 1'b1;
  assign fa     = (base_q + ADDR_W'(k_q)) & mask_i;
  assign lane_o = lane0_q + k_q;

  // next-state logic
  always_comb begin
    st_d = st_q; base_d = base_q; lane0_d = lane0_q; nf_d = nf_q;
    k_d = k_q; cnt_d = cnt_q;
    clr_o = 1'b0; smp_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        clr_o   = 1'b1;
        base_d  = addr_i & mask_i;
        lane0_d = addr_i[1:0];
        nf_d    = fetches_m1(size_i);
        k_d     = '0;
        cnt_d   = '0;
        st_d    = !present_i ? ST_DONE : (big_i ? ST_LSET : ST_FETCH);
      end
      ST_LSET: st_d = ST_LSTB;
      ST_LSTB: st_d = ST_LHLD;
      ST_LHLD: st_d = ST_FETCH;
      ST_FETCH: begin
        if (cnt_q == wlast) begin
          smp_o = 1'b1;
          cnt_d = '0;
          if (k_q == nf_q) st_d = ST_DONE;
          else begin
            k_d  = k_q + 2'd1;
            st_d = big_i ? ST_LSET : ST_FETCH;
          end
        end else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;  // ST_DONE
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; base_q <= '0; lane0_q <= '0; nf_q <= '0;
      k_q <= '0; cnt_q <= '0;
    end else begin
      st_q <= st_d; base_q <= base_d; lane0_q <= lane0_d; nf_q <= nf_d;
      k_q <= k_d; cnt_q <= cnt_d;
    end
  end

  // output decode from state
  always_comb begin
    rom_addr_o = '0;
    rom_cs_n_o = 1'b1;
    rom_oe_n_o = 1'b1;
    ready_o    = (st_q == ST_DONE);
    case (st_q)
      ST_LSET, ST_LSTB, ST_LHLD: begin
        rom_addr_o[HI_LO-1:0]     = fa[HI_LO-1:0];
        rom_addr_o[HI_LO +: HI_W] = fa[ADDR_W-1 -: HI_W];
        rom_addr_o[LINES-1]       = (st_q == ST_LSTB);
      end
      ST_FETCH: begin
        rom_addr_o = fa[LINES-1:0];
        if (big_i) rom_addr_o[LINES-1] = 1'b0;
        rom_cs_n_o = 1'b0;
        rom_oe_n_o = 1'b0;
      end
      default: ;
    endcase
  end

  // latch strobe is exactly one cycle wide (R8)
  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    big_i && rom_addr_o[LINES-1] |=> !rom_addr_o[LINES-1]);

  // every chip-select fall on a large ROM follows a strobe two cycles back (R8)
  p_hi_before_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    big_i && $fell(rom_cs_n_o) |-> $past(rom_addr_o[LINES-1], 2));

  // read strobe only inside chip select (R9)
  p_oe_in_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n_o |-> !rom_cs_n_o);

  // ready is a single pulse (R4)
  p_ready_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);
endmodule

// File: rtl/rom_lane_pack.sv
module rom_lane_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        wr_i,
  input  logic [1:0]  lane_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] data_o
);
  logic [31:0] data_d;

  always_comb begin
    data_d = data_o;
    if (clr_i) data_d = '0;
    else if (wr_i) data_d[8*lane_i +: 8] = byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_o <= '0;
    else if (clr_i || wr_i) data_o <= data_d;
  end
endmodule

// File: rtl/bootrom_reader.sv
module bootrom_reader #(
  parameter int ADDR_W = 18,
  parameter int LINES  = 15,
  parameter int HI_LO  = 10,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [1:0]        rd_size,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [2:0]        rom_size,
  input  logic [WAIT_W-1:0] fetch_wait,
  output logic [31:0]       rd_data,
  output logic              rd_ready,
  output logic [LINES-1:0]  rom_addr,
  output logic              rom_cs_n,
  output logic              rom_oe_n,
  input  logic [7:0]        rom_data
);
  logic              present, big, clr, smp;
  logic [ADDR_W-1:0] mask;
  logic [1:0]        lane;

  rom_size_decode #(.ADDR_W(ADDR_W), .LINES(LINES)) u_dec (
    .code_i(rom_size), .present_o(present), .big_o(big), .mask_o(mask));

  rom_fetch_seq #(.ADDR_W(ADDR_W), .LINES(LINES), .HI_LO(HI_LO), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(rd_start), .size_i(rd_size),
    .addr_i(host_addr), .present_i(present), .big_i(big), .mask_i(mask),
    .wait_i(fetch_wait), .clr_o(clr), .smp_o(smp), .lane_o(lane),
    .ready_o(rd_ready), .rom_addr_o(rom_addr), .rom_cs_n_o(rom_cs_n),
    .rom_oe_n_o(rom_oe_n));

  rom_lane_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_i(smp), .lane_i(lane),
    .byte_i(rom_data), .data_o(rd_data));

  // no ROM fitted: chip select never asserted (R6)
  p_no_rom_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !present |-> rom_cs_n);
endmodule

// File: tb/bootrom_reader_bench.sv
module bootrom_reader_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] data;
    int          lat;
    int          oe_cyc;
    int          start_cyc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, rd_start = 1'b0;
  logic [1:0]  rd_size = '0;
  logic [17:0] host_addr = '0;
  logic [2:0]  rom_size = 3'b100;
  logic [3:0]  fetch_wait = 4'd8;
  logic [31:0] rd_data;
  logic        rd_ready, rom_cs_n, rom_oe_n;
  logic [14:0] rom_addr;
  logic [7:0]  rom_data;

  int checks = 0, errors = 0, cyc = 0, oe_acc = 0, resp = 0, pushed = 0;
  bit finished = 0;
  exp_t q[$];

  bootrom_reader u_bootrom_reader (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_size(rd_size),
    .host_addr(host_addr), .rom_size(rom_size), .fetch_wait(fetch_wait),
    .rd_data(rd_data), .rd_ready(rd_ready), .rom_addr(rom_addr),
    .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .rom_data(rom_data));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rom_byte(input logic [17:0] a);
    return a[7:0] ^ a[17:10] ^ 8'h5A;
  endfunction

  // ROM model with an external latch on line 14
  logic       big_cfg;
  logic [3:0] hi_lat = '0;
  logic [17:0] cur;
  assign big_cfg = (rom_size >= 3'd5);
  always @(posedge rom_addr[14]) hi_lat <= rom_addr[13:10];
  assign cur = big_cfg ? {hi_lat, rom_addr[13:0]} : {3'b000, rom_addr};
  assign rom_data = (!rom_cs_n && !rom_oe_n) ? rom_byte(cur) : 8'h00;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: compute expectation independently, push, pulse start
  task automatic do_read(input logic [2:0] code, input logic [3:0] w,
                         input logic [1:0] sz, input logic [17:0] addr,
                         input string tag);
    exp_t e;
    int nf, weff, lat_l, bits;
    logic [17:0] mask, a;
    logic [1:0] lane;
    nf   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    weff = (w == 0) ? 1 : int'(w);
    e.data = '0;
    if (code[2:1] == 2'b00) begin
      e.lat = 1; e.oe_cyc = 0;
    end else begin
      bits  = int'(code) + 11;
      mask  = 18'((1 << bits) - 1);
      lat_l = (code >= 3'd5) ? 3 : 0;
      for (int k = 0; k < nf; k++) begin
        a    = ((addr & mask) + 18'(k)) & mask;
        lane = addr[1:0] + 2'(k);
        e.data[8*lane +: 8] = rom_byte(a);
      end
      e.lat = nf * (weff + lat_l) + 1;
      e.oe_cyc = nf * weff;
    end
    e.tag = tag;
    @(negedge clk);
    rom_size = code; fetch_wait = w; rd_size = sz; host_addr = addr;
    rd_start = 1'b1;
    e.start_cyc = cyc;
    q.push_back(e); pushed++;
    @(negedge clk);
    rd_start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pop and compare at each ready pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (!rom_oe_n) oe_acc++;
      if (rd_ready) begin
        resp++;
        if (q.size() == 0) chk(0, "R10", "unexpected ready", 32'(resp), 32'(pushed));
        else begin
          exp_t e;
          e = q.pop_front();
          chk(rd_data == e.data, e.tag, "data", rd_data, e.data);
          chk(cyc - e.start_cyc == e.lat, "R4", {e.tag, " latency"},
              32'(cyc - e.start_cyc), 32'(e.lat));
          chk(oe_acc == e.oe_cyc, "R9", {e.tag, " strobe cycles"},
              32'(oe_acc), 32'(e.oe_cyc));
        end
        oe_acc = 0;
      end
    end
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
          errors++; checks++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_ready == 0, "R4", "reset ready", 32'(rd_ready), 0);
    chk(rom_cs_n && rom_oe_n, "R9", "reset strobes", {rom_cs_n, rom_oe_n}, 2'b11);
    chk(rom_addr == 0, "R7", "reset addr", 32'(rom_addr), 0);

    // R1 R5 R7: 32K byte read, A14 set, bits above 32K ignored
    do_read(3'b100, 4'd8, 2'b00, 18'h3C005, "R1/R5/R7");
    do_read(3'b100, 4'd8, 2'b00, 18'h07FFE, "R1/R7");
    // R2: word with lane wrap on 16K
    do_read(3'b011, 4'd8, 2'b01, 18'h02133, "R2/R5");
    // R2 R5: 8K word wrapping the top of the ROM
    do_read(3'b010, 4'd8, 2'b01, 18'h01FFF, "R2/R5");
    // R3 R8: 256K dword crossing a 16K boundary (latched bits change)
    do_read(3'b111, 4'd8, 2'b10, 18'h1BFFE, "R3/R8");
    // R3 R8 R5: 64K dword wrapping within size, upper bits ignored
    do_read(3'b101, 4'd8, 2'b11, 18'h3FFFE, "R3/R8/R5");
    // R8: 128K byte read
    do_read(3'b110, 4'd8, 2'b00, 18'h15A52, "R1/R8");
    // R9: short wait and zero wait
    do_read(3'b100, 4'd3, 2'b10, 18'h01230, "R3/R9");
    do_read(3'b111, 4'd0, 2'b01, 18'h2C001, "R2/R9");
    // R6: no ROM fitted, both codes
    do_read(3'b000, 4'd8, 2'b10, 18'h00100, "R6");
    do_read(3'b001, 4'd8, 2'b00, 18'h00003, "R6");

    // R10: a start during a busy read is dropped
    fork
      do_read(3'b101, 4'd4, 2'b10, 18'h0A000, "R10/R3");
      begin
        repeat (4) @(negedge clk);
        rd_size = 2'b00; host_addr = 18'h00011; rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
      end
    join
    repeat (40) @(negedge clk);
    chk(resp == pushed, "R10", "response count", 32'(resp), 32'(pushed));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule